// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which of a serial port's five interrupt causes is reported to software, and drives the interrupt request line. Each clock it looks at the interrupt-enable bits, the receive error and data-ready flags, the modem-status change flags, the receive queue fill level against a selectable trigger, and its own internal state. It then registers a 4-bit identification code. The interrupt request is raised whenever that code differs from the "nothing pending" code.

Two pieces of state live inside the block. The first is a character-timeout counter. It counts clocks while received data sits unread, and it restarts whenever software reads the receive buffer or a new character arrives. The second is a transmitter-empty pending flag. A shift-register load sets it, and a holding-register write or a read of the identification register clears it. The surrounding register file drives the read-strobe and event inputs and returns the identification byte on reads.

Top module: `uart_iid`

## Requirements
- R1: While synchronous active-low reset is applied, the identification byte reads 0xC1 and the interrupt request is low. The timeout counter and the transmitter-empty pending flag clear.
- R2: When enable bit 2 is set and any receive error bit is set (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break), the code is 0x6. This cause beats every other cause. With enable bit 2 clear, the error bits have no effect.
- R3: When enable bit 0 is set, data-ready is high and the fill count is at or above the trigger, the code is 0x4. The trigger select values 0, 1, 2 and 3 give levels of 1, 4, 8 and 14 entries. Without data-ready there is no 0x4.
- R4: When enable bit 0 is set and the timeout counter has reached 4 times the per-character clock count, the code is 0xC. The counter adds one per clock while data-ready is high and holds at that threshold.
- R5: A receive-buffer read strobe or a character-push strobe returns the timeout counter to zero.
- R6: A shift-register load strobe sets the pending flag. When enable bit 1 is set, the holding-empty input is high and the flag is set, the code is 0x2. A holding-register write strobe or an identification-read strobe clears the flag. A load in the same cycle as a clear wins.
- R7: When enable bit 3 is set and any modem change bit is set, the code is 0x0.
- R8: When several causes are active, the code names the highest one. The order is line status, then received data, then timeout, then transmitter empty, then modem status. With no cause active the code is 0x1.
- R9: The identification byte has bits 7:6 at 1, bits 5:4 at 0, and the code in bits 3:0.
- R10: The interrupt request is high exactly when the code is not 0x1.
- R11: The code is registered. A change at the inputs shows on the outputs after the next rising clock edge, and the internal state feeds the code one edge after it is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_i | input | 4 | Enables: 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem |
| ls_err_i | input | 4 | Receive errors: 0 overrun, 1 parity, 2 framing, 3 break |
| rx_ready_i | input | 1 | Receive data-ready flag |
| rx_count_i | input | CNT_W | Receive queue fill count |
| trig_sel_i | input | 2 | Receive trigger level select |
| char_clks_i | input | CLK_W | Clocks per character |
| rx_pop_i | input | 1 | Receive-buffer read strobe |
| rx_push_i | input | 1 | New received character strobe |
| ms_delta_i | input | 4 | Modem status change flags |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tx_load_i | input | 1 | Shift register loaded strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A level cause reaches the outputs after one rising edge, because the code is a single register. A strobe that changes internal state takes two edges: the state updates on the first edge, and the code reflects it on the second. The timeout code therefore appears 4·N+1 edges after data-ready rises, where N is the per-character clock count. The bench drives inputs on the falling edge and samples one falling edge after each rising edge. For strobe-driven cases it checks both the stale value after the first edge and the new value after the second. The timeout case checks the cycle just before expiry and the cycle of expiry. It also lets the counter run past its would-be expiry after a push strobe, so a missing restart is seen.

// File: rtl/uart_iid_pkg.sv
// Shared codes and helpers for the UART interrupt identification unit.
// Assumes source index 0 is the highest priority.
package uart_iid_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_code_e;

    localparam int NUM_SRC = 5;

    localparam int SRC_LINE    = 0;
    localparam int SRC_RXDATA  = 1;
    localparam int SRC_TIMEOUT = 2;
    localparam int SRC_TXEMPTY = 3;
    localparam int SRC_MODEM   = 4;

    localparam logic [1:0] RD_HIGH_FILL = 2'b11;
    localparam logic [1:0] RD_MID_FILL  = 2'b00;

    // Map a priority index to its identification code.
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            SRC_LINE:    return IID_LINE;
            SRC_RXDATA:  return IID_RXDATA;
            SRC_TIMEOUT: return IID_TIMEOUT;
            SRC_TXEMPTY: return IID_TXEMPTY;
            SRC_MODEM:   return IID_MODEM;
            default:     return IID_NONE;
        endcase
    endfunction

    // Map the trigger select field to a fill level in entries.
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_iid_prio.sv
// Fixed-priority encoder: turns a request vector into an identification code.
// Assumes req_i[0] is the highest priority; no request gives the idle code.
module uart_iid_prio
    import uart_iid_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req_i,
    output logic [3:0]   code_o
);

    // Walk from lowest to highest priority so the highest active one wins.
    always_comb begin
        code_o = IID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = src_code(i);
        end
    end

endmodule

// File: rtl/uart_iid_tmo.sv
// Character-timeout counter: counts clocks while data waits, saturating at
// MULT times the per-character clock count. Assumes restart has priority.
module uart_iid_tmo #(
    parameter int CLK_W = 16,
    parameter int MULT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             restart_i,
    input  logic [CLK_W-1:0] char_clks_i,
    output logic             expired_o
);

    localparam int TMO_W = CLK_W + $clog2(MULT) + 1;

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] thresh;

    // Threshold is the character time scaled by the timeout multiple.
    always_comb thresh = TMO_W'(char_clks_i) * TMO_W'(MULT);

    // Count while data is waiting; restart on read or push; hold at threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart_i)
            cnt_q <= '0;
        else if (ready_i && (cnt_q < thresh))
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry once the threshold is reached.
    always_comb expired_o = (cnt_q >= thresh);

endmodule

// File: rtl/uart_iid_thre.sv
// Transmitter-empty pending flag: set on a shift-register load, cleared by a
// holding write or an identification read. Assumes a load beats a clear.
module uart_iid_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic clr_wr_i,
    input  logic clr_rd_i,
    output logic pend_o
);

    // Track the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (load_i)
            pend_o <= 1'b1;
        else if (clr_wr_i || clr_rd_i)
            pend_o <= 1'b0;
    end

endmodule

// File: rtl/uart_iid.sv
// UART interrupt identification unit top. Qualifies the five causes with
// their enables, picks the highest and registers the code. Assumes strobes
// are single-cycle and that the fill count is wide enough for a level of 14.
module uart_iid
    import uart_iid_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int CLK_W    = 16,
    parameter int TMO_MULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_i,
    input  logic [3:0]       ls_err_i,
    input  logic             rx_ready_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [1:0]       trig_sel_i,
    input  logic [CLK_W-1:0] char_clks_i,
    input  logic             rx_pop_i,
    input  logic             rx_push_i,
    input  logic [3:0]       ms_delta_i,
    input  logic             thr_empty_i,
    input  logic             tx_load_i,
    input  logic             thr_wr_i,
    input  logic             iir_rd_i,
    output logic [7:0]       iir_o,
    output logic             irq_o
);

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    logic               tmo_expired;
    logic               thre_pend;
    logic               trig_hit;
    logic [NUM_SRC-1:0] req;
    logic [3:0]         code_next;
    logic [3:0]         code_q;

    uart_iid_tmo #(
        .CLK_W (CLK_W),
        .MULT  (TMO_MULT)
    ) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (rx_ready_i),
        .restart_i   (rx_pop_i | rx_push_i),
        .char_clks_i (char_clks_i),
        .expired_o   (tmo_expired)
    );

    uart_iid_thre u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tx_load_i),
        .clr_wr_i (thr_wr_i),
        .clr_rd_i (iir_rd_i),
        .pend_o   (thre_pend)
    );

    // Compare the fill count with the selected trigger level.
    always_comb trig_hit = (int'(rx_count_i) >= trig_level(trig_sel_i));

    // Qualify each cause with its enable bit.
    always_comb begin
        req              = '0;
        req[SRC_LINE]    = ier_i[EN_LINE]  && (|ls_err_i);
        req[SRC_RXDATA]  = ier_i[EN_RX]    && rx_ready_i && trig_hit;
        req[SRC_TIMEOUT] = ier_i[EN_RX]    && tmo_expired;
        req[SRC_TXEMPTY] = ier_i[EN_TX]    && thr_empty_i && thre_pend;
        req[SRC_MODEM]   = ier_i[EN_MODEM] && (|ms_delta_i);
    end

    uart_iid_prio #(
        .N (NUM_SRC)
    ) u_prio (
        .req_i  (req),
        .code_o (code_next)
    );

    // Register the identification code once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= IID_NONE;
        else
            code_q <= code_next;
    end

    // Present the read byte and the request line.
    always_comb begin
        iir_o = {RD_HIGH_FILL, RD_MID_FILL, code_q};
        irq_o = (code_q != IID_NONE);
    end

endmodule

// File: rtl/uart_iid_chk.sv
// Assertion checker for uart_iid, bound to every instance of the top.
module uart_iid_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier_i,
    input logic [3:0] ls_err_i,
    input logic [3:0] ms_delta_i,
    input logic       tx_load_i,
    input logic       iir_rd_i,
    input logic [7:0] iir_o,
    input logic       irq_o
);

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[2] && (|ls_err_i)) |=> (iir_o[3:0] == 4'h6)); // R2

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_i[0]) |=> (iir_o[3:0] != 4'hC) && (iir_o[3:0] != 4'h4)); // R4

    AST_TX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd_i && !tx_load_i) ##1 (ier_i == 4'b0010 && !tx_load_i)
        |=> (iir_o[3:0] == 4'h1)); // R6

    AST_MODEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i == 4'b1000 && (|ms_delta_i)) |=> (iir_o[3:0] == 4'h0)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i == 4'b0000) |=> !irq_o); // R10

endmodule

bind uart_iid uart_iid_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier_i      (ier_i),
    .ls_err_i   (ls_err_i),
    .ms_delta_i (ms_delta_i),
    .tx_load_i  (tx_load_i),
    .iir_rd_i   (iir_rd_i),
    .iir_o      (iir_o),
    .irq_o      (irq_o)
);

// File: tb/uart_iid_tb.sv
// Directed bench for uart_iid: one task per scenario, each checking itself.
module uart_iid_tb;

    localparam int CNT_W = 5;
    localparam int CLK_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ier_i = '0;
    logic [3:0]       ls_err_i = '0;
    logic             rx_ready_i = 1'b0;
    logic [CNT_W-1:0] rx_count_i = '0;
    logic [1:0]       trig_sel_i = '0;
    logic [CLK_W-1:0] char_clks_i = 16'd1000;
    logic             rx_pop_i = 1'b0;
    logic             rx_push_i = 1'b0;
    logic [3:0]       ms_delta_i = '0;
    logic             thr_empty_i = 1'b0;
    logic             tx_load_i = 1'b0;
    logic             thr_wr_i = 1'b0;
    logic             iir_rd_i = 1'b0;
    logic [7:0]       iir_o;
    logic             irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_iid #(
        .CNT_W (CNT_W),
        .CLK_W (CLK_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_i       (ier_i),
        .ls_err_i    (ls_err_i),
        .rx_ready_i  (rx_ready_i),
        .rx_count_i  (rx_count_i),
        .trig_sel_i  (trig_sel_i),
        .char_clks_i (char_clks_i),
        .rx_pop_i    (rx_pop_i),
        .rx_push_i   (rx_push_i),
        .ms_delta_i  (ms_delta_i),
        .thr_empty_i (thr_empty_i),
        .tx_load_i   (tx_load_i),
        .thr_wr_i    (thr_wr_i),
        .iir_rd_i    (iir_rd_i),
        .iir_o       (iir_o),
        .irq_o       (irq_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Check the byte and the request line together (R9, R10).
    task automatic chk_iir(input string req, input logic [7:0] exp);
        chk(req, iir_o, exp);
        chk({req, " R10 irq"}, {7'd0, irq_o}, {7'd0, exp != 8'hC1});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ier_i = '0; ls_err_i = '0; rx_ready_i = 0; rx_count_i = '0;
        trig_sel_i = '0; char_clks_i = 16'd1000; rx_pop_i = 0; rx_push_i = 0;
        ms_delta_i = '0; thr_empty_i = 0; tx_load_i = 0; thr_wr_i = 0; iir_rd_i = 0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ier_i = 4'hF; ls_err_i = 4'hF; ms_delta_i = 4'hF;
        step();
        chk_iir("R1 reset idle", 8'hC1);
        do_reset();
        step();
        chk_iir("R1 idle after reset", 8'hC1);
    endtask

    task automatic t_line();
        do_reset();
        for (int b = 0; b < 4; b++) begin
            ier_i = 4'b0100;
            ls_err_i = 4'(1 << b);
            step();
            chk_iir($sformatf("R2 error bit %0d", b), 8'hC6);
        end
        ier_i = 4'b1011;
        ls_err_i = 4'hF;
        step();
        chk_iir("R2 ignored when disabled", 8'hC1);
        ls_err_i = '0;
    endtask

    task automatic t_rxdata();
        do_reset();
        ier_i = 4'b0001;
        rx_ready_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            trig_sel_i = 2'(s);
            rx_count_i = CNT_W'(lvl - 1);
            step();
            chk_iir($sformatf("R3 below level sel %0d", s), 8'hC1);
            rx_count_i = CNT_W'(lvl);
            step();
            chk_iir($sformatf("R3 at level sel %0d", s), 8'hC4);
        end
        rx_ready_i = 1'b0;
        step();
        chk_iir("R3 needs data-ready", 8'hC1);
    endtask

    task automatic t_timeout();
        do_reset();
        char_clks_i = 16'd3;
        ier_i = 4'b0011;
        thr_empty_i = 1'b1;
        rx_count_i = CNT_W'(1);
        trig_sel_i = 2'd1;
        tx_load_i = 1'b1;
        step();
        tx_load_i = 1'b0;
        rx_ready_i = 1'b1;
        step();
        chk_iir("R8 tx empty before timeout", 8'hC2);
        repeat (11) step();
        chk_iir("R4 one cycle before expiry", 8'hC2);
        step();
        chk_iir("R4 expiry at 4 char times", 8'hCC);
        rx_count_i = CNT_W'(4);
        step();
        chk_iir("R8 rx data over timeout", 8'hC4);
        rx_count_i = CNT_W'(1);
        step();
        chk_iir("R4 timeout holds", 8'hCC);
        rx_pop_i = 1'b1;
        step();
        rx_pop_i = 1'b0;
        chk_iir("R11 pop seen one edge later", 8'hCC);
        step();
        chk_iir("R5 pop restarts", 8'hC2);
        repeat (10) step();
        rx_push_i = 1'b1;
        step();
        rx_push_i = 1'b0;
        repeat (10) step();
        chk_iir("R5 push restarts", 8'hC2);
        rx_ready_i = 1'b0;
    endtask

    task automatic t_thre();
        do_reset();
        ier_i = 4'b0010;
        thr_empty_i = 1'b1;
        tx_load_i = 1'b1;
        step();
        tx_load_i = 1'b0;
        chk_iir("R11 load seen one edge later", 8'hC1);
        step();
        chk_iir("R6 pending after load", 8'hC2);
        thr_empty_i = 1'b0;
        step();
        chk_iir("R6 needs holding empty", 8'hC1);
        thr_empty_i = 1'b1;
        thr_wr_i = 1'b1;
        step();
        thr_wr_i = 1'b0;
        step();
        chk_iir("R6 holding write clears", 8'hC1);
        tx_load_i = 1'b1;
        iir_rd_i = 1'b1;
        step();
        tx_load_i = 1'b0;
        iir_rd_i = 1'b0;
        step();
        chk_iir("R6 load beats read clear", 8'hC2);
        iir_rd_i = 1'b1;
        step();
        iir_rd_i = 1'b0;
        step();
        chk_iir("R6 read clears", 8'hC1);
    endtask

    task automatic t_modem();
        do_reset();
        for (int b = 0; b < 4; b++) begin
            ier_i = 4'b1000;
            ms_delta_i = 4'(1 << b);
            step();
            chk_iir($sformatf("R7 change bit %0d", b), 8'hC0);
        end
        ier_i = 4'b0111;
        step();
        chk_iir("R7 ignored when disabled", 8'hC1);
        ms_delta_i = '0;
    endtask

    task automatic t_prio();
        do_reset();
        ier_i = 4'hF;
        thr_empty_i = 1'b1;
        tx_load_i = 1'b1;
        step();
        tx_load_i = 1'b0;
        ls_err_i = 4'b0001;
        rx_ready_i = 1'b1;
        rx_count_i = CNT_W'(14);
        trig_sel_i = 2'd0;
        ms_delta_i = 4'b0001;
        step();
        chk_iir("R8 line status first", 8'hC6);
        ls_err_i = '0;
        step();
        chk_iir("R8 rx data second", 8'hC4);
        rx_ready_i = 1'b0;
        step();
        chk_iir("R8 tx empty over modem", 8'hC2);
        iir_rd_i = 1'b1;
        step();
        iir_rd_i = 1'b0;
        chk_iir("R11 read clear seen one edge later", 8'hC2);
        step();
        chk_iir("R8 modem last", 8'hC0);
        ms_delta_i = '0;
        step();
        chk_iir("R8 none active", 8'hC1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_line();
        t_rxdata();
        t_timeout();
        t_thre();
        t_modem();
        t_prio();
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

endmodule